// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers level-sensitive request lines from on-chip peripherals, together with a 4-bit encoded level from an external interrupt source, and tells the processor which request to service. Software assigns each source a 4-bit priority through a small set of priority registers. Every register carries four priority fields. Several sources can be tied to one field, so a peripheral with several causes gets a single priority for all of them. A subset of the sources can also be masked. This is done through a pair of write-one registers: one sets mask bits and the other clears them.

On every clock the block looks at all pending, unmasked, enabled requests and picks the highest priority. If two requests tie, the external input wins over all internal sources, and among internal sources the lowest index wins. The block registers the chosen priority level and its 12-bit exception vector code and drives both to the processor. Internal source i uses vector 0x400 + 0x20*i. External code k uses vector 0x200 + 0x20*k. The mapping from sources to fields and the set of maskable sources are parameters.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, irqLevel and irqVector are 0, every priority register reads 0 and the mask reads 0. Whenever irqLevel is 0, irqVector is 0.
- R2: Register address r (0 to NUM_PRIO_REGS-1) is a 16-bit priority register. Its field f sits in bits [4f+3:4f] and is priority field number 4r+f. A read returns the 16 bits in rdData[15:0] with the upper bits 0.
- R3: A pending, unmasked internal source i whose field priority is nonzero presents level = that priority and vector = 0x400 + 0x20*i. With the default map, source i uses field 0,1,2,2,3,3,3,3,4,5,6,6 for i = 0..11.
- R4: A field priority of 0 disables every source tied to that field.
- R5: The highest level among candidates wins. On a tie between internal sources, the lowest source index wins.
- R6: Sources mapped to one field share its priority, so one write to that field changes the level of every member.
- R7: A write to address 4 sets each maskable mask bit whose data bit is 1. A write to address 5 clears each mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged. Reading address 4 or 5 returns the mask in bits [NUM_SRC-1:0], with mask bit i belonging to source i.
- R8: A masked source is not a candidate. Sources outside MASKABLE (default sources 8 to 11 are maskable) ignore mask writes, read back 0 and always stay candidates.
- R9: An external code k from 0 to 14 is a candidate with level 15-k and vector 0x200 + 0x20*k. Code 15 means no external request. The external request wins ties against internal sources.
- R10: Requests are level-sensitive. A source counts as pending only while its line is high, and when it drops, the next pending request takes over.
- R11: The outputs follow a change on srcReq or extLevel at the next clock edge. They follow a register write at the second edge after the write is presented, so they keep the old value for one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address (priority registers, mask set, mask clear) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| srcReq | input | NUM_SRC | Level-sensitive internal request lines |
| extLevel | input | 4 | Encoded external level, 15 = none |
| irqLevel | output | 4 | Priority of the selected request, 0 = none |
| irqVector | output | 12 | Exception vector code of the selected request |

## Verification
The arbitration is tried with several patterns, each aimed at one kind of fault:
- A single request, which shows the field lookup and the vector arithmetic.
- Two requests with different priorities, which shows the ordering.
- Two members of one group at equal priority, which shows that the lowest index wins ties.
- An external code against an internal source of the same level, which shows that the external input wins ties.

Further patterns cover the register side and timing:
- Masking patterns write set and clear words that contain both ones and zeros, including bits of non-maskable sources, which separates write-one semantics from plain register writes.
- Dropping the winning line shows that requests are level-sensitive.
- A priority rewrite checked at both the first and the second edge pins down the pipeline depth.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int PRIO_W        = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int REG_DW        = PRIO_W * FIELDS_PER_REG;
  localparam int BUS_DW        = 32;
  localparam int ADDR_W        = 3;
  localparam int VEC_W         = 12;
  localparam int SEL_W         = 4;

  localparam logic [ADDR_W-1:0] ADDR_MASK_SET = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MASK_CLR = 3'd5;
  localparam logic [PRIO_W-1:0] EXT_NONE      = 4'hF;

  // Strobes from the decode logic to the register datapath.
  typedef struct packed {
    logic              prioWr;
    logic [SEL_W-1:0]  prioSel;
    logic              maskSet;
    logic              maskClr;
    logic [BUS_DW-1:0] data;
  } vicStrobe_t;

endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_PRIO_REGS = 2
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_DW-1:0] busWdata,
  output vicStrobe_t        strb
);

  always_comb begin
    strb      = '0;
    strb.data = busWdata;
    if (busWr) begin
      if (int'(busAddr) < NUM_PRIO_REGS) begin
        strb.prioWr  = 1'b1;
        strb.prioSel = SEL_W'(busAddr);
      end else if (busAddr == ADDR_MASK_SET) begin
        strb.maskSet = 1'b1;
      end else if (busAddr == ADDR_MASK_CLR) begin
        strb.maskClr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int                 NUM_SRC       = 12,
  parameter int                 NUM_PRIO_REGS = 2,
  parameter logic [NUM_SRC-1:0] MASKABLE      = 12'hF00,
  localparam int                NUM_FIELD     = NUM_PRIO_REGS * FIELDS_PER_REG
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  vicStrobe_t                  strb,
  input  logic [ADDR_W-1:0]           busAddr,
  output logic [BUS_DW-1:0]           busRdata,
  output logic [NUM_FIELD*PRIO_W-1:0] fieldPrio,
  output logic [NUM_SRC-1:0]          maskVec,
  input  logic [PRIO_W-1:0]           nextLevel,
  input  logic [VEC_W-1:0]            nextVector,
  output logic [PRIO_W-1:0]           irqLevel,
  output logic [VEC_W-1:0]            irqVector
);

  logic [REG_DW-1:0]  prioQ [NUM_PRIO_REGS];
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] setBits;
  logic [NUM_SRC-1:0] clrBits;

  for (genvar r = 0; r < NUM_PRIO_REGS; r++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioQ[r] <= '0;
      end else if (strb.prioWr && strb.prioSel == SEL_W'(r)) begin
        prioQ[r] <= strb.data[REG_DW-1:0];
      end
    end
    assign fieldPrio[REG_DW*r +: REG_DW] = prioQ[r];
  end

  assign setBits = strb.maskSet ? (strb.data[NUM_SRC-1:0] & MASKABLE) : '0;
  assign clrBits = strb.maskClr ? strb.data[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else begin
      maskQ <= (maskQ | setBits) & ~clrBits;
    end
  end

  assign maskVec = maskQ;

  always_comb begin
    busRdata = '0;
    for (int r = 0; r < NUM_PRIO_REGS; r++) begin
      if (int'(busAddr) == r) begin
        busRdata[REG_DW-1:0] = prioQ[r];
      end
    end
    if (busAddr == ADDR_MASK_SET || busAddr == ADDR_MASK_CLR) begin
      busRdata[NUM_SRC-1:0] = maskQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLevel  <= '0;
      irqVector <= '0;
    end else begin
      irqLevel  <= nextLevel;
      irqVector <= nextVector;
    end
  end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int                   NUM_SRC      = 12,
  parameter int                   NUM_FIELD    = 8,
  parameter logic [NUM_SRC*4-1:0] FIELD_MAP    = 48'h665433332210,
  parameter int                   INT_VEC_BASE = 'h400,
  parameter int                   EXT_VEC_BASE = 'h200,
  parameter int                   VEC_STEP     = 'h20
) (
  input  logic [NUM_SRC-1:0]          srcReq,
  input  logic [NUM_SRC-1:0]          maskVec,
  input  logic [NUM_FIELD*PRIO_W-1:0] fieldPrio,
  input  logic [PRIO_W-1:0]           extLevel,
  output logic [PRIO_W-1:0]           nextLevel,
  output logic [VEC_W-1:0]            nextVector
);

  logic [PRIO_W-1:0] effPrio [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int FieldIdx = int'(FIELD_MAP[4*i +: 4]);
    assign effPrio[i] = (srcReq[i] && !maskVec[i]) ? fieldPrio[PRIO_W*FieldIdx +: PRIO_W] : '0;
  end

  always_comb begin
    logic [PRIO_W-1:0] bestLvl;
    logic [VEC_W-1:0]  bestVec;
    if (extLevel != EXT_NONE) begin
      bestLvl = PRIO_W'(15 - int'(extLevel));
      bestVec = VEC_W'(EXT_VEC_BASE + VEC_STEP * int'(extLevel));
    end else begin
      bestLvl = '0;
      bestVec = '0;
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (effPrio[i] > bestLvl) begin
        bestLvl = effPrio[i];
        bestVec = VEC_W'(INT_VEC_BASE + VEC_STEP * i);
      end
    end
    if (bestLvl == '0) begin
      bestVec = '0;
    end
    nextLevel  = bestLvl;
    nextVector = bestVec;
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int                   NUM_SRC       = 12,
  parameter int                   NUM_PRIO_REGS = 2,
  parameter logic [NUM_SRC*4-1:0] FIELD_MAP     = 48'h665433332210,
  parameter logic [NUM_SRC-1:0]   MASKABLE      = 12'hF00,
  parameter int                   INT_VEC_BASE  = 'h400,
  parameter int                   EXT_VEC_BASE  = 'h200,
  parameter int                   VEC_STEP      = 'h20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [2:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [3:0]         extLevel,
  output logic [3:0]         irqLevel,
  output logic [11:0]        irqVector
);

  localparam int NumField = NUM_PRIO_REGS * FIELDS_PER_REG;

  vicStrobe_t                 strb;
  logic [NumField*PRIO_W-1:0] fieldPrio;
  logic [NUM_SRC-1:0]         maskVec;
  logic [PRIO_W-1:0]          nextLevel;
  logic [VEC_W-1:0]           nextVector;

  vic_ctrl #(.NUM_PRIO_REGS(NUM_PRIO_REGS)) ctrl_i (
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strb     (strb)
  );

  vic_regs #(
    .NUM_SRC       (NUM_SRC),
    .NUM_PRIO_REGS (NUM_PRIO_REGS),
    .MASKABLE      (MASKABLE)
  ) regs_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busAddr    (busAddr),
    .busRdata   (busRdata),
    .fieldPrio  (fieldPrio),
    .maskVec    (maskVec),
    .nextLevel  (nextLevel),
    .nextVector (nextVector),
    .irqLevel   (irqLevel),
    .irqVector  (irqVector)
  );

  vic_arbiter #(
    .NUM_SRC      (NUM_SRC),
    .NUM_FIELD    (NumField),
    .FIELD_MAP    (FIELD_MAP),
    .INT_VEC_BASE (INT_VEC_BASE),
    .EXT_VEC_BASE (EXT_VEC_BASE),
    .VEC_STEP     (VEC_STEP)
  ) arb_i (
    .srcReq     (srcReq),
    .maskVec    (maskVec),
    .fieldPrio  (fieldPrio),
    .extLevel   (extLevel),
    .nextLevel  (nextLevel),
    .nextVector (nextVector)
  );

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int                 NUM_SRC      = 12,
  parameter logic [NUM_SRC-1:0] MASKABLE     = 12'hF00,
  parameter int                 INT_VEC_BASE = 'h400,
  parameter int                 EXT_VEC_BASE = 'h200,
  parameter int                 VEC_STEP     = 'h20
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWr,
  input logic [2:0]         busAddr,
  input logic [31:0]        busWdata,
  input logic [NUM_SRC-1:0] srcReq,
  input logic [3:0]         extLevel,
  input logic [3:0]         irqLevel,
  input logic [11:0]        irqVector,
  input logic [NUM_SRC-1:0] maskVec
);

  a_r1_idle_vector_zero: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == 4'd0) |-> (irqVector == 12'd0));

  a_r9_ext_vector_matches_level: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != 4'd0 && int'(irqVector) < INT_VEC_BASE) |->
      (int'(irqVector) == EXT_VEC_BASE + VEC_STEP * (15 - int'(irqLevel))));

  a_r9_ext_level_floor: assert property (@(posedge clk) disable iff (!rstN)
    (extLevel != 4'hF) |=> (int'(irqLevel) >= 15 - int'($past(extLevel))));

  a_r10_no_request_no_output: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq == '0 && extLevel == 4'hF) |=> (irqLevel == 4'd0));

  a_r7_mask_set_takes: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd4) |=>
      ((maskVec & $past(busWdata[NUM_SRC-1:0] & MASKABLE)) == $past(busWdata[NUM_SRC-1:0] & MASKABLE)));

  a_r7_mask_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd5) |=> ((maskVec & $past(busWdata[NUM_SRC-1:0])) == '0));

endmodule

bind vec_irq_ctrl vic_checker #(
  .NUM_SRC      (NUM_SRC),
  .MASKABLE     (MASKABLE),
  .INT_VEC_BASE (INT_VEC_BASE),
  .EXT_VEC_BASE (EXT_VEC_BASE),
  .VEC_STEP     (VEC_STEP)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .srcReq    (srcReq),
  .extLevel  (extLevel),
  .irqLevel  (irqLevel),
  .irqVector (irqVector),
  .maskVec   (maskVec)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb_top;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [11:0] srcReq = '0;
  logic [3:0]  extLevel = 4'hF;
  logic [3:0]  irqLevel;
  logic [11:0] irqVector;

  always #(ClkPeriod/2) clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcReq(srcReq),
    .extLevel(extLevel), .irqLevel(irqLevel), .irqVector(irqVector)
  );

  typedef struct {
    logic [3:0]  lvl;
    logic [11:0] vec;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        chk({it.tag, " level"}, 32'(irqLevel), 32'(it.lvl));
        chk({it.tag, " vector"}, 32'(irqVector), 32'(it.vec));
      end
    end
  end

  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readCheck(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(tag, busRdata, exp);
  endtask

  task automatic drive(logic [11:0] req, logic [3:0] ext);
    @(negedge clk);
    srcReq = req; extLevel = ext;
  endtask

  // Driver: one edge later the outputs must show the expected item.
  task automatic expectNext(logic [3:0] lvl, logic [11:0] vec, string tag);
    expItem_t it;
    @(posedge clk);
    it.lvl = lvl; it.vec = vec; it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 level", 32'(irqLevel), 0);
    chk("R1 vector", 32'(irqVector), 0);
    readCheck(3'd0, 32'h0, "R1 prio reg");
    readCheck(3'd4, 32'h0, "R1 mask");

    // R2 priority register layout and readback
    busWrite(3'd0, 32'hFFFF_4321);
    busWrite(3'd1, 32'h0000_0765);
    readCheck(3'd0, 32'h0000_4321, "R2 reg0 readback");
    readCheck(3'd1, 32'h0000_0765, "R2 reg1 readback");

    // R3 single source
    drive(12'h001, 4'hF); expectNext(4'd1, 12'h400, "R3 src0");
    // R5 higher priority wins
    drive(12'h003, 4'hF); expectNext(4'd2, 12'h420, "R5 src1 over src0");
    // R6 group member uses shared field
    drive(12'h008, 4'hF); expectNext(4'd3, 12'h460, "R6 src3 field2");
    // R5 tie inside group: lowest index
    drive(12'h00C, 4'hF); expectNext(4'd3, 12'h440, "R5 tie lowest index");

    // R6 + R11: rewrite field2, observe at second edge
    busWrite(3'd0, 32'h0000_4521);
    chk("R11 old level held one edge", 32'(irqLevel), 32'd3);
    expectNext(4'd5, 12'h440, "R6 R11 group rewrite");

    // R4 zero priority disables
    busWrite(3'd0, 32'h0000_4021);
    drive(12'h004, 4'hF); expectNext(4'd0, 12'h000, "R4 field zero");
    busWrite(3'd0, 32'h0000_4321);

    // R7/R8 masking
    drive(12'h100, 4'hF); expectNext(4'd5, 12'h500, "R3 src8");
    busWrite(3'd4, 32'h0000_0100);
    readCheck(3'd4, 32'h0000_0100, "R7 set readback");
    expectNext(4'd0, 12'h000, "R8 masked src8");
    busWrite(3'd5, 32'h0000_0000);
    readCheck(3'd5, 32'h0000_0100, "R7 zero clear keeps");
    busWrite(3'd4, 32'h0000_0200);
    readCheck(3'd4, 32'h0000_0300, "R7 set keeps others");
    busWrite(3'd5, 32'h0000_0100);
    readCheck(3'd4, 32'h0000_0200, "R7 clear one bit");
    expectNext(4'd5, 12'h500, "R7 unmasked src8");
    busWrite(3'd4, 32'hFFFF_FFFF);
    readCheck(3'd4, 32'h0000_0F00, "R8 non-maskable read zero");
    drive(12'h001, 4'hF); expectNext(4'd1, 12'h400, "R8 non-maskable still wins");
    busWrite(3'd5, 32'hFFFF_FFFF);
    readCheck(3'd5, 32'h0000_0000, "R7 clear all");

    // R9 external levels
    drive(12'h000, 4'd0);  expectNext(4'd15, 12'h200, "R9 ext code0");
    drive(12'h000, 4'd14); expectNext(4'd1, 12'h3C0, "R9 ext code14");
    drive(12'h000, 4'hF);  expectNext(4'd0, 12'h000, "R9 ext none");
    drive(12'h002, 4'd13); expectNext(4'd2, 12'h3A0, "R9 ext wins tie");
    drive(12'h002, 4'hF);  expectNext(4'd2, 12'h420, "R9 ext gone");

    // R10 level-sensitive handover
    drive(12'h402, 4'hF); expectNext(4'd7, 12'h540, "R10 src10");
    drive(12'h002, 4'hF); expectNext(4'd2, 12'h420, "R10 src10 dropped");
    drive(12'h000, 4'hF); expectNext(4'd0, 12'h000, "R10 all dropped");

    @(negedge clk);
    wait (expQ.size() == 0);
    @(negedge clk);
    finished = 1;
    summary();
  end

endmodule